// File: doc/BRIEF.md
# Two-Cycle Flash Command Decoder

This block sits behind the host-facing word bus of a NOR-style flash macro. Bus writes arrive already sampled into the clock domain as one-cycle strobes carrying an address and a data word. The block reads the low byte of each write as a command code. Some codes act at once. Others open a two-write sequence whose second write supplies a confirm code, a lock sub-code or a data word. Completed sequences become single-cycle requests to the write-state controller and the lock tracker. Sequences that break the rules are reported as a sequence error or a protection error.

The block also holds the read mode selected by the last mode-setting command. It steers the read data port to one of four sources: the array, an identifier window, the query source or the status word. The identifier window returns two fixed codes, the per-block lock bits, and the one-time-programmable area with its lock word. Each address in that window is decoded by the block.

Top module: `cfd_cmd_decoder`

## Requirements
- R1: After reset the read mode is array (rd_mode = 0), and req_valid, seq_err and prot_err are low.
- R2: With no sequence open, code FFh selects array mode (0), 90h identifier mode (1), 98h query mode (2) and 70h status mode (3). rd_data returns array_rdata, query_rdata or status_word in modes 0, 2 and 3.
- R3: In identifier mode, address 0 reads 00B0h and address 1 reads 00A1h. Address 80h reads {14'b0, otp_lock}, and 81h–88h read otp_rdata. An address at offset 2 of its lock block reads {14'b0, lock_bits}, where lock blocks are 4 Kwords below 10000h and 64 Kwords above. Every other address reads 0.
- R4: The pairs 20h+D0h, 30h+D0h, and 40h or 10h followed by any word issue requests of kind 1 (block erase), 2 (chip erase) and 3 (program). The request carries the address and data of the second write.
- R5: If the second write of an erase pair is not D0h, or the second write of a 60h pair is not 01h, D0h or 2Fh, seq_err is raised and no request is issued.
- R6: If the second write's address differs from the first write's address, seq_err is raised and no request is issued.
- R7: 60h followed by 01h, D0h or 2Fh issues kind 5 (set lock), 6 (clear lock) or 7 (set lock-down).
- R8: C0h followed by a data word issues kind 4 only when the address lies in 80h–88h. Address 80h is always accepted. Addresses 81h–84h are refused while otp_lock[0] is set, and 85h–88h while otp_lock[1] is set. A refused pair raises prot_err and issues no request.
- R9: The second write of any two-write sequence leaves the read mode at status (3), whatever its outcome.
- R10: With no sequence open, 50h issues kind 10 (clear status). B0h issues kind 8 (suspend) and D0h issues kind 9 (resume), and both of these select status mode.
- R11: Any other code, written with no sequence open, issues nothing and leaves the read mode unchanged.
- R12: req_valid, seq_err and prot_err are registered single-cycle pulses. They are asserted in the cycle after the write that completes a command, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data; the low byte is the command code |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Steered read data (combinational) |
| rd_mode | output | 2 | Current read mode: 0 array, 1 identifier, 2 query, 3 status |
| array_rdata | input | DW | Array data at rd_addr |
| query_rdata | input | DW | Query data at rd_addr |
| status_word | input | DW | Status word from the write-state controller |
| otp_rdata | input | DW | One-time-programmable area data at rd_addr |
| lock_bits | input | 2 | Lock state of the block holding rd_addr (bit 0 locked, bit 1 locked-down) |
| otp_lock | input | 2 | OTP lock bits: bit 0 guards the low half, bit 1 the high half |
| req_valid | output | 1 | Request strobe |
| req_kind | output | 4 | Request kind code |
| req_addr | output | AW | Request address |
| req_data | output | DW | Request data |
| seq_err | output | 1 | Improper command sequence pulse |
| prot_err | output | 1 | Refused OTP program pulse |

## Verification
The decoder holds three pieces of hidden state: the open-sequence flag, the stored first opcode and address, and the read mode. A wrong read mode shows on rd_mode and on rd_data as soon as the clock edge that follows the write has passed. A corrupt open-sequence flag or stored opcode stays hidden until the next write. That write then produces the wrong request kind, a spurious seq_err, or no pulse, and the error appears in the single cycle after it. The directed tests therefore follow every first write with a second write that tells a correct stored state from a wrong one.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

   typedef enum logic [1:0] {
      MODE_ARRAY  = 2'd0,
      MODE_ID     = 2'd1,
      MODE_QUERY  = 2'd2,
      MODE_STATUS = 2'd3
   } rd_mode_e;

   localparam logic [3:0] K_NONE     = 4'd0;
   localparam logic [3:0] K_ERASE    = 4'd1;
   localparam logic [3:0] K_CHIP     = 4'd2;
   localparam logic [3:0] K_PROG     = 4'd3;
   localparam logic [3:0] K_OTP      = 4'd4;
   localparam logic [3:0] K_LOCK_SET = 4'd5;
   localparam logic [3:0] K_LOCK_CLR = 4'd6;
   localparam logic [3:0] K_LOCK_DN  = 4'd7;
   localparam logic [3:0] K_SUSPEND  = 4'd8;
   localparam logic [3:0] K_RESUME   = 4'd9;
   localparam logic [3:0] K_CLR_STAT = 4'd10;

   localparam logic [7:0] C_ARRAY   = 8'hFF;
   localparam logic [7:0] C_STATUS  = 8'h70;
   localparam logic [7:0] C_CLRSTAT = 8'h50;
   localparam logic [7:0] C_SUSPEND = 8'hB0;
   localparam logic [7:0] C_CONFIRM = 8'hD0;
   localparam logic [7:0] C_IDENT   = 8'h90;
   localparam logic [7:0] C_QUERY   = 8'h98;
   localparam logic [7:0] C_ERASE   = 8'h20;
   localparam logic [7:0] C_CHIP    = 8'h30;
   localparam logic [7:0] C_PROG_A  = 8'h40;
   localparam logic [7:0] C_PROG_B  = 8'h10;
   localparam logic [7:0] C_OTP     = 8'hC0;
   localparam logic [7:0] C_LOCK    = 8'h60;
   localparam logic [7:0] C_LK_SET  = 8'h01;
   localparam logic [7:0] C_LK_DOWN = 8'h2F;

   function automatic logic is_known(input logic [7:0] op);
      case (op)
         C_ARRAY, C_STATUS, C_CLRSTAT, C_SUSPEND, C_CONFIRM, C_IDENT,
         C_QUERY, C_ERASE, C_CHIP, C_PROG_A, C_PROG_B, C_OTP, C_LOCK:
            return 1'b1;
         default:
            return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/cfd_otp_win.sv
module cfd_otp_win #(
   parameter int AW        = 21,
   parameter int OTP_BASE  = 'h80,
   parameter int OTP_WORDS = 8
) (
   input  logic [AW-1:0] addr,
   input  logic [1:0]    guard,
   output logic          is_lock_word,
   output logic          is_data,
   output logic          locked
);
   localparam logic [AW-1:0] LW       = AW'(OTP_BASE);
   localparam logic [AW-1:0] LAST     = AW'(OTP_BASE + OTP_WORDS);
   localparam logic [AW-1:0] HALF_END = AW'(OTP_BASE + OTP_WORDS / 2);

   logic upper_half;

   assign is_lock_word = (addr == LW);
   assign is_data      = (addr > LW) && (addr <= LAST);
   assign upper_half   = (addr > HALF_END);
   assign locked       = is_data && (upper_half ? guard[1] : guard[0]);
endmodule

// File: rtl/cfd_seq.sv
module cfd_seq
   import cfd_pkg::*;
#(
   parameter int AW        = 21,
   parameter int DW        = 16,
   parameter int OTP_BASE  = 'h80,
   parameter int OTP_WORDS = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [1:0]    otp_lock,
   output rd_mode_e      mode,
   output logic          pend,
   output logic          req_valid,
   output logic [3:0]    req_kind,
   output logic [AW-1:0] req_addr,
   output logic [DW-1:0] req_data,
   output logic          seq_err,
   output logic          prot_err
);
   logic [7:0]    op;
   logic [7:0]    pend_op, pend_op_nx;
   logic [AW-1:0] pend_addr, pend_addr_nx;
   logic          pend_nx;
   rd_mode_e      mode_nx;
   logic [3:0]    kind_nx;
   logic          se_nx, pe_nx;
   logic          w_lockw, w_data, w_locked, w_ok;

   assign op = wr_data[7:0];

   cfd_otp_win #(.AW(AW), .OTP_BASE(OTP_BASE), .OTP_WORDS(OTP_WORDS)) u_wwin (
      .addr(wr_addr), .guard(otp_lock),
      .is_lock_word(w_lockw), .is_data(w_data), .locked(w_locked)
   );
   assign w_ok = w_lockw || (w_data && !w_locked);

   always_comb begin
      mode_nx      = mode;
      pend_nx      = pend;
      pend_op_nx   = pend_op;
      pend_addr_nx = pend_addr;
      kind_nx      = K_NONE;
      se_nx        = 1'b0;
      pe_nx        = 1'b0;
      if (wr_en) begin
         if (pend) begin
            pend_nx = 1'b0;
            mode_nx = MODE_STATUS;
            if (wr_addr != pend_addr) begin
               se_nx = 1'b1;
            end else begin
               case (pend_op)
                  C_ERASE:  if (op == C_CONFIRM) kind_nx = K_ERASE; else se_nx = 1'b1;
                  C_CHIP:   if (op == C_CONFIRM) kind_nx = K_CHIP;  else se_nx = 1'b1;
                  C_PROG_A: kind_nx = K_PROG;
                  C_OTP:    if (w_ok) kind_nx = K_OTP; else pe_nx = 1'b1;
                  C_LOCK: begin
                     case (op)
                        C_LK_SET:  kind_nx = K_LOCK_SET;
                        C_CONFIRM: kind_nx = K_LOCK_CLR;
                        C_LK_DOWN: kind_nx = K_LOCK_DN;
                        default:   se_nx   = 1'b1;
                     endcase
                  end
                  default:  se_nx = 1'b1;
               endcase
            end
         end else begin
            case (op)
               C_ARRAY:   mode_nx = MODE_ARRAY;
               C_STATUS:  mode_nx = MODE_STATUS;
               C_IDENT:   mode_nx = MODE_ID;
               C_QUERY:   mode_nx = MODE_QUERY;
               C_CLRSTAT: kind_nx = K_CLR_STAT;
               C_SUSPEND: begin kind_nx = K_SUSPEND; mode_nx = MODE_STATUS; end
               C_CONFIRM: begin kind_nx = K_RESUME;  mode_nx = MODE_STATUS; end
               C_ERASE, C_CHIP, C_OTP, C_LOCK, C_PROG_A, C_PROG_B: begin
                  pend_nx      = 1'b1;
                  pend_op_nx   = (op == C_PROG_B) ? C_PROG_A : op;
                  pend_addr_nx = wr_addr;
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode      <= MODE_ARRAY;
         pend      <= 1'b0;
         pend_op   <= '0;
         pend_addr <= '0;
         req_valid <= 1'b0;
         req_kind  <= K_NONE;
         req_addr  <= '0;
         req_data  <= '0;
         seq_err   <= 1'b0;
         prot_err  <= 1'b0;
      end else begin
         mode      <= mode_nx;
         pend      <= pend_nx;
         pend_op   <= pend_op_nx;
         pend_addr <= pend_addr_nx;
         req_valid <= (kind_nx != K_NONE);
         req_kind  <= kind_nx;
         seq_err   <= se_nx;
         prot_err  <= pe_nx;
         if (wr_en) begin
            req_addr <= wr_addr;
            req_data <= wr_data;
         end
      end
   end
endmodule

// File: rtl/cfd_rd_steer.sv
module cfd_rd_steer
   import cfd_pkg::*;
#(
   parameter int          AW          = 21,
   parameter int          DW          = 16,
   parameter int          OTP_BASE    = 'h80,
   parameter int          OTP_WORDS   = 8,
   parameter int          SMALL_AW    = 12,
   parameter int          LARGE_AW    = 16,
   parameter int unsigned SMALL_LIMIT = 32'h10000,
   parameter logic [15:0] MFR_CODE    = 16'h00B0,
   parameter logic [15:0] DEV_CODE    = 16'h00A1
) (
   input  rd_mode_e      mode,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] array_rdata,
   input  logic [DW-1:0] query_rdata,
   input  logic [DW-1:0] status_word,
   input  logic [DW-1:0] otp_rdata,
   input  logic [1:0]    lock_bits,
   input  logic [1:0]    otp_lock,
   output logic [DW-1:0] rd_data
);
   localparam logic [AW-1:0] SLIM = AW'(SMALL_LIMIT);

   logic          r_lockw, r_data, r_locked_unused;
   logic          lock_hit;
   logic [DW-1:0] id_word;

   cfd_otp_win #(.AW(AW), .OTP_BASE(OTP_BASE), .OTP_WORDS(OTP_WORDS)) u_rwin (
      .addr(addr), .guard(2'b00),
      .is_lock_word(r_lockw), .is_data(r_data), .locked(r_locked_unused)
   );

   if (SMALL_AW == LARGE_AW) begin : g_uniform
      assign lock_hit = (addr[SMALL_AW-1:0] == SMALL_AW'(2));
   end else begin : g_split
      assign lock_hit = (addr < SLIM) ? (addr[SMALL_AW-1:0] == SMALL_AW'(2))
                                      : (addr[LARGE_AW-1:0] == LARGE_AW'(2));
   end

   always_comb begin
      if (addr == '0)             id_word = DW'(MFR_CODE);
      else if (addr == AW'(1))    id_word = DW'(DEV_CODE);
      else if (r_lockw)           id_word = DW'(otp_lock);
      else if (r_data)            id_word = otp_rdata;
      else if (lock_hit)          id_word = DW'(lock_bits);
      else                        id_word = '0;
   end

   always_comb begin
      case (mode)
         MODE_ID:     rd_data = id_word;
         MODE_QUERY:  rd_data = query_rdata;
         MODE_STATUS: rd_data = status_word;
         default:     rd_data = array_rdata;
      endcase
   end
endmodule

// File: rtl/cfd_cmd_decoder.sv
module cfd_cmd_decoder
   import cfd_pkg::*;
#(
   parameter int          AW          = 21,
   parameter int          DW          = 16,
   parameter int          OTP_BASE    = 'h80,
   parameter int          OTP_WORDS   = 8,
   parameter int          SMALL_AW    = 12,
   parameter int          LARGE_AW    = 16,
   parameter int unsigned SMALL_LIMIT = 32'h10000,
   parameter logic [15:0] MFR_CODE    = 16'h00B0,
   parameter logic [15:0] DEV_CODE    = 16'h00A1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic [1:0]    rd_mode,
   input  logic [DW-1:0] array_rdata,
   input  logic [DW-1:0] query_rdata,
   input  logic [DW-1:0] status_word,
   input  logic [DW-1:0] otp_rdata,
   input  logic [1:0]    lock_bits,
   input  logic [1:0]    otp_lock,
   output logic          req_valid,
   output logic [3:0]    req_kind,
   output logic [AW-1:0] req_addr,
   output logic [DW-1:0] req_data,
   output logic          seq_err,
   output logic          prot_err
);
   if (DW < 16) begin : g_bad_dw
      $error("cfd_cmd_decoder: DW must be at least 16");
   end
   if (OTP_WORDS < 2 || (OTP_WORDS % 2) != 0) begin : g_bad_otp
      $error("cfd_cmd_decoder: OTP_WORDS must be even and at least 2");
   end
   if (LARGE_AW < SMALL_AW || AW <= LARGE_AW) begin : g_bad_blk
      $error("cfd_cmd_decoder: need SMALL_AW <= LARGE_AW < AW");
   end

   rd_mode_e mode;
   logic     pend;

   cfd_seq #(.AW(AW), .DW(DW), .OTP_BASE(OTP_BASE), .OTP_WORDS(OTP_WORDS)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .otp_lock(otp_lock), .mode(mode), .pend(pend),
      .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
      .req_data(req_data), .seq_err(seq_err), .prot_err(prot_err)
   );

   cfd_rd_steer #(
      .AW(AW), .DW(DW), .OTP_BASE(OTP_BASE), .OTP_WORDS(OTP_WORDS),
      .SMALL_AW(SMALL_AW), .LARGE_AW(LARGE_AW), .SMALL_LIMIT(SMALL_LIMIT),
      .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
   ) u_steer (
      .mode(mode), .addr(rd_addr), .array_rdata(array_rdata),
      .query_rdata(query_rdata), .status_word(status_word),
      .otp_rdata(otp_rdata), .lock_bits(lock_bits), .otp_lock(otp_lock),
      .rd_data(rd_data)
   );

   assign rd_mode = mode;
endmodule

// File: rtl/cfd_cmd_decoder_chk.sv
module cfd_cmd_decoder_chk
   import cfd_pkg::*;
#(
   parameter int AW        = 21,
   parameter int OTP_BASE  = 'h80,
   parameter int OTP_WORDS = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [7:0]    wr_op,
   input logic          pend,
   input logic [1:0]    rd_mode,
   input logic          req_valid,
   input logic [3:0]    req_kind,
   input logic [AW-1:0] req_addr,
   input logic          seq_err,
   input logic          prot_err
);
   localparam logic [AW-1:0] LO = AW'(OTP_BASE);
   localparam logic [AW-1:0] HI = AW'(OTP_BASE + OTP_WORDS);

   // R12: at most one outcome per cycle
   a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_valid, seq_err, prot_err}));

   // R12: every outcome follows a write
   a_r12_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid || seq_err || prot_err) |-> $past(wr_en));

   // R9: closing write of a sequence leaves status mode
   a_r9_status_after: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && pend) |=> (rd_mode == 2'd3));

   // R4: block erase request only after a confirm code
   a_r4_erase_confirm: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == K_ERASE) |-> ($past(wr_op) == C_CONFIRM));

   // R8: OTP program requests stay inside the window
   a_r8_otp_window: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == K_OTP) |-> (req_addr >= LO && req_addr <= HI));

   // R11: reserved code with no open sequence changes nothing
   a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !pend && !is_known(wr_op)) |=>
         (rd_mode == $past(rd_mode) && !req_valid && !seq_err));

   // R2: FFh returns to array mode
   a_r2_array: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !pend && wr_op == C_ARRAY) |=> (rd_mode == 2'd0));
endmodule

bind cfd_cmd_decoder cfd_cmd_decoder_chk #(
   .AW(AW), .OTP_BASE(OTP_BASE), .OTP_WORDS(OTP_WORDS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_data[7:0]),
   .pend(pend), .rd_mode(rd_mode), .req_valid(req_valid),
   .req_kind(req_kind), .req_addr(req_addr), .seq_err(seq_err),
   .prot_err(prot_err)
);

// File: tb/cfd_cmd_decoder_test.sv
module cfd_cmd_decoder_test;
   localparam int  AW = 21;
   localparam int  DW = 16;
   localparam time TCLK = 10ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic [1:0]    rd_mode;
   logic [DW-1:0] array_rdata, query_rdata, otp_rdata;
   logic [DW-1:0] status_word = 16'h0080;
   logic [1:0]    lock_bits = 2'b00;
   logic [1:0]    otp_lock = 2'b00;
   logic          req_valid, seq_err, prot_err;
   logic [3:0]    req_kind;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   assign array_rdata = rd_addr[15:0] ^ 16'h5A5A;
   assign query_rdata = ~rd_addr[15:0];
   assign otp_rdata   = {8'h07, rd_addr[7:0]};

   always #(TCLK / 2) clk = ~clk;

   cfd_cmd_decoder uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .rd_mode(rd_mode), .array_rdata(array_rdata), .query_rdata(query_rdata),
      .status_word(status_word), .otp_rdata(otp_rdata), .lock_bits(lock_bits),
      .otp_lock(otp_lock), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_data(req_data), .seq_err(seq_err),
      .prot_err(prot_err)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // one write strobe; returns at the negedge after the capturing edge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
      rd_addr = a;
      #1;
      check(tag, rd_data, exp);
   endtask

   task automatic expect_out(input string tag, input logic v, input logic [3:0] k,
                             input logic se, input logic pe);
      check({tag, " valid"}, req_valid, v);
      if (v) check({tag, " kind"}, req_kind, k);
      check({tag, " seq_err"}, seq_err, se);
      check({tag, " prot_err"}, prot_err, pe);
   endtask

   task automatic t_reset;
      check("R1 mode", rd_mode, 2'd0);
      expect_out("R1", 1'b0, 4'd0, 1'b0, 1'b0);
      rd("R1 array read", 21'h00123, 16'h0123 ^ 16'h5A5A);
   endtask

   task automatic t_modes;
      wr(21'h0, 16'h0070);
      check("R2 status mode", rd_mode, 2'd3);
      rd("R2 status data", 21'h00010, 16'h0080);
      wr(21'h0, 16'h0098);
      check("R2 query mode", rd_mode, 2'd2);
      rd("R2 query data", 21'h00020, ~16'h0020);
      wr(21'h0, 16'h0090);
      check("R2 id mode", rd_mode, 2'd1);
      wr(21'h0, 16'h00FF);
      check("R2 array mode", rd_mode, 2'd0);
      rd("R2 array data", 21'h00777, 16'h0777 ^ 16'h5A5A);
   endtask

   task automatic t_ident;
      wr(21'h0, 16'h0090);
      rd("R3 mfr code", 21'h0, 16'h00B0);
      rd("R3 dev code", 21'h1, 16'h00A1);
      lock_bits = 2'b01;
      rd("R3 lock small blk0", 21'h00002, 16'h0001);
      lock_bits = 2'b11;
      rd("R3 lock small blk3", 21'h03002, 16'h0003);
      rd("R3 lock large blk", 21'h20002, 16'h0003);
      rd("R3 large non-offset", 21'h21002, 16'h0000);
      rd("R3 not offset2", 21'h20012, 16'h0000);
      otp_lock = 2'b10;
      rd("R3 otp lock word", 21'h00080, 16'h0002);
      rd("R3 otp data", 21'h00083, 16'h0783);
      rd("R3 otp last", 21'h00088, 16'h0788);
      rd("R3 past window", 21'h00089, 16'h0000);
      otp_lock = 2'b00;
   endtask

   task automatic t_erase_prog;
      wr(21'h30000, 16'h0020);
      expect_out("R4 erase first", 1'b0, 4'd0, 1'b0, 1'b0);
      wr(21'h30000, 16'h00D0);
      expect_out("R4 erase", 1'b1, 4'd1, 1'b0, 1'b0);
      check("R4 erase addr", req_addr, 21'h30000);
      check("R9 status after erase", rd_mode, 2'd3);
      wr(21'h0, 16'h00FF);
      wr(21'h00000, 16'h0030);
      wr(21'h00000, 16'h00D0);
      expect_out("R4 chip erase", 1'b1, 4'd2, 1'b0, 1'b0);
      wr(21'h01234, 16'h0040);
      wr(21'h01234, 16'hBEEF);
      expect_out("R4 program 40h", 1'b1, 4'd3, 1'b0, 1'b0);
      check("R4 program data", req_data, 16'hBEEF);
      wr(21'h01235, 16'h0010);
      wr(21'h01235, 16'h00FF);
      expect_out("R4 program 10h", 1'b1, 4'd3, 1'b0, 1'b0);
      check("R4 program data FF", req_data, 16'h00FF);
      @(negedge clk);
      check("R12 pulse drops", req_valid, 1'b0);
   endtask

   task automatic t_bad_seq;
      wr(21'h0, 16'h00FF);
      wr(21'h40000, 16'h0020);
      wr(21'h40000, 16'h00FF);
      expect_out("R5 erase bad confirm", 1'b0, 4'd0, 1'b1, 1'b0);
      check("R9 status after error", rd_mode, 2'd3);
      // the FF in the second cycle must not have been taken as a mode change
      wr(21'h0, 16'h0050);
      expect_out("R5 sequence closed", 1'b1, 4'd10, 1'b0, 1'b0);
      wr(21'h50000, 16'h0060);
      wr(21'h50000, 16'h0055);
      expect_out("R5 lock bad code", 1'b0, 4'd0, 1'b1, 1'b0);
      wr(21'h01000, 16'h0040);
      wr(21'h01001, 16'h1234);
      expect_out("R6 program addr mismatch", 1'b0, 4'd0, 1'b1, 1'b0);
      wr(21'h60000, 16'h0020);
      wr(21'h70000, 16'h00D0);
      expect_out("R6 erase addr mismatch", 1'b0, 4'd0, 1'b1, 1'b0);
   endtask

   task automatic t_lock;
      wr(21'h08000, 16'h0060);
      wr(21'h08000, 16'h0001);
      expect_out("R7 set lock", 1'b1, 4'd5, 1'b0, 1'b0);
      wr(21'h08000, 16'h0060);
      wr(21'h08000, 16'h00D0);
      expect_out("R7 clear lock", 1'b1, 4'd6, 1'b0, 1'b0);
      wr(21'h08000, 16'h0060);
      wr(21'h08000, 16'h002F);
      expect_out("R7 lock down", 1'b1, 4'd7, 1'b0, 1'b0);
      check("R9 status after lock", rd_mode, 2'd3);
   endtask

   task automatic t_otp;
      otp_lock = 2'b01;
      wr(21'h00082, 16'h00C0);
      wr(21'h00082, 16'h1111);
      expect_out("R8 low half locked", 1'b0, 4'd0, 1'b0, 1'b1);
      wr(21'h00086, 16'h00C0);
      wr(21'h00086, 16'h2222);
      expect_out("R8 high half open", 1'b1, 4'd4, 1'b0, 1'b0);
      check("R8 otp addr", req_addr, 21'h00086);
      otp_lock = 2'b10;
      wr(21'h00086, 16'h00C0);
      wr(21'h00086, 16'h2222);
      expect_out("R8 high half locked", 1'b0, 4'd0, 1'b0, 1'b1);
      wr(21'h00084, 16'h00C0);
      wr(21'h00084, 16'h3333);
      expect_out("R8 low half open", 1'b1, 4'd4, 1'b0, 1'b0);
      otp_lock = 2'b11;
      wr(21'h00080, 16'h00C0);
      wr(21'h00080, 16'h0003);
      expect_out("R8 lock word always", 1'b1, 4'd4, 1'b0, 1'b0);
      otp_lock = 2'b00;
      wr(21'h00090, 16'h00C0);
      wr(21'h00090, 16'h4444);
      expect_out("R8 outside window", 1'b0, 4'd0, 1'b0, 1'b1);
   endtask

   task automatic t_single;
      wr(21'h0, 16'h00FF);
      wr(21'h0, 16'h00B0);
      expect_out("R10 suspend", 1'b1, 4'd8, 1'b0, 1'b0);
      check("R10 suspend mode", rd_mode, 2'd3);
      wr(21'h0, 16'h0090);
      wr(21'h0, 16'h00D0);
      expect_out("R10 resume", 1'b1, 4'd9, 1'b0, 1'b0);
      check("R10 resume mode", rd_mode, 2'd3);
      wr(21'h0, 16'h0098);
      wr(21'h0, 16'h0050);
      expect_out("R10 clear status", 1'b1, 4'd10, 1'b0, 1'b0);
      check("R10 clear keeps mode", rd_mode, 2'd2);
   endtask

   task automatic t_reserved;
      wr(21'h0, 16'h0090);
      wr(21'h0, 16'h0077);
      expect_out("R11 reserved 77h", 1'b0, 4'd0, 1'b0, 1'b0);
      check("R11 mode kept", rd_mode, 2'd1);
      rd("R11 id read kept", 21'h0, 16'h00B0);
      wr(21'h0, 16'h00E8);
      expect_out("R11 reserved E8h", 1'b0, 4'd0, 1'b0, 1'b0);
      check("R11 mode kept 2", rd_mode, 2'd1);
      // a reserved code must not open a sequence: D0h next acts as resume
      wr(21'h0, 16'h00D0);
      expect_out("R11 no open sequence", 1'b1, 4'd9, 1'b0, 1'b0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_modes();
      t_ident();
      t_erase_prog();
      t_bad_seq();
      t_lock();
      t_otp();
      t_single();
      t_reserved();
      finish_run();
   end
endmodule